// File: doc/BRIEF.md
# Debug Pin Acknowledge and Abort Controller

This block sits on the target side of a single-wire, open-drain debug pin and runs in the serial clock domain. One clock cycle is one serial clock period. When the command decoder reports a complete command, the block treats an acknowledge as pending. When the decoder later reports that the command has finished, the block drives the acknowledge pulse. That pulse is a low level driven by the target, followed by a single driven-high speedup cycle. At all other times the block releases the pin, and the external pull-up supplies the high level.

While an acknowledge is pending, the host can cancel it by holding the pin low. The block times every low pulse it sees on the pin, after a two-flop synchronizer. A low pulse that persists for `ABORT_MIN` cycles cancels the pending acknowledge and raises `abort_o`. The command decoder uses `abort_o` to re-arm, so it takes the next falling edge as the first bit of a new command. The abort also raises `cancel_o` when the command itself may be stopped. A run-type command keeps running, and so does a memory access that has already begun. In both cases only their acknowledge is lost. A low pulse of `SYNC_LEN` cycles or more is reported as a sync request on `sync_req_o` once the pin returns high. A stop indication that arrives while a command is pending drops the command silently.

All control pins are plain levels or single-cycle strobes. No data streams through the block, so there is no valid/ready back-pressure.

Top module: `dbgpin_abort`

## Requirements
- R1: After reset, `pin_low_o`, `pin_high_o`, `abort_o`, `cancel_o` and `sync_req_o` are all 0.
- R2: A `cmd_done_i` strobe while an acknowledge is pending drives `pin_low_o` for exactly `ACK_LEN` (default 16) consecutive cycles, starting the cycle after the strobe. Then `pin_high_o` is driven for exactly one cycle. Then both are released. The two drives are never active together.
- R3: Only one acknowledge is outstanding at a time. A `cmd_pend_i` while one is pending or being driven is ignored. A `cmd_done_i` with nothing pending produces no pin drive.
- R4: A `stop_i` while an acknowledge is pending drops the command. No acknowledge is ever driven for it, and neither `abort_o` nor `cancel_o` is raised.
- R5: While an acknowledge is pending, a low pulse on the pin lasting at least `ABORT_MIN` (default 4) cycles raises `abort_o` and removes the pending state, so a later `cmd_done_i` drives nothing. A shorter pulse changes nothing.
- R6: A low pulse of at least `SYNC_LEN` (default 128) cycles raises `sync_req_o` after the pin returns high, whether or not anything is pending. A shorter pulse never raises it. The pulse-length counter saturates and does not wrap.
- R7: `cmd_class_i` is captured with `cmd_pend_i` (0 = other, 1 = read, 2 = write, 3 = run). `cancel_o` pulses together with `abort_o` only when the captured class is not 3 and `acc_busy_i` is 0. Otherwise the command keeps running, and only its acknowledge is cancelled.
- R8: After an abort, the next `cmd_pend_i` is accepted, and its `cmd_done_i` produces a normal acknowledge.
- R9: Pin levels caused by the block's own acknowledge, including a short settling window after it, are not timed as host pulses. The block's own acknowledge never raises `abort_o` or `sync_req_o`.
- R10: `abort_o`, `cancel_o` and `sync_req_o` are single-cycle strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Debug pin level as read back from the pad |
| cmd_pend_i | input | 1 | Strobe: a command was received and awaits acknowledge |
| cmd_done_i | input | 1 | Strobe: the pending command has finished |
| stop_i | input | 1 | Stop condition seen; drop a pending command |
| cmd_class_i | input | 2 | Command class, captured with `cmd_pend_i` |
| acc_busy_i | input | 1 | A memory access of the pending command has begun |
| pin_low_o | output | 1 | Drive pin low (acknowledge pulse) |
| pin_high_o | output | 1 | Drive pin high (speedup cycle) |
| abort_o | output | 1 | Strobe: pending acknowledge cancelled; re-arm command reception |
| cancel_o | output | 1 | Strobe: pending command itself stopped |
| sync_req_o | output | 1 | Strobe: long low pulse detected, sync requested |

## Verification
The bench sweeps the host low-pulse length over every value from 1 to 135 cycles, once with an acknowledge pending and once with none. This separates the glitch, abort and sync bands at both thresholds, 3/4 and 127/128. The command class and the access-busy flag rotate across the sweep, so each cancel decision is compared against a value computed from the class and flag. Pending commands that survive a short pulse are then cleared with a stop. That shows a stop drives no acknowledge. Separate sequences exercise a normal acknowledge, measured cycle by cycle; nested and unmatched commands; and a fresh acknowledge after an abort or a sync.

// File: rtl/dbgpin_abort_pkg.sv
package dbgpin_abort_pkg;

  typedef enum logic [1:0] {
    CLS_OTHER = 2'd0,
    CLS_READ  = 2'd1,
    CLS_WRITE = 2'd2,
    CLS_RUN   = 2'd3
  } cmd_class_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_ACKL = 2'd2,
    ST_SPDH = 2'd3
  } ack_state_e;

endpackage

// File: rtl/dbgpin_lowtimer.sv
module dbgpin_lowtimer #(
  parameter int SYNC_LEN  = 128,
  parameter int ABORT_MIN = 4,
  parameter int STAGES    = 2,
  localparam int CW = $clog2(SYNC_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic guard_i,
  output logic abort_evt_o,
  output logic sync_evt_o
);

  localparam logic [CW-1:0] SAT     = CW'(SYNC_LEN);
  localparam logic [CW-1:0] ABT_HIT = CW'(ABORT_MIN - 1);

  logic [STAGES-1:0] sync_q;
  logic              pin_s;
  logic [CW-1:0]     low_cnt;

  // metastability chain; pin idles high through the pull-up
  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= pin_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[STAGES-2:0], pin_i};
      end
    end
  endgenerate

  assign pin_s = sync_q[STAGES-1];

  // counts low cycles of the synchronized pin, saturating at SYNC_LEN
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
    end else if (guard_i || pin_s) begin
      low_cnt <= '0;
    end else if (low_cnt != SAT) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  assign abort_evt_o = !guard_i && !pin_s && (low_cnt == ABT_HIT);
  assign sync_evt_o  = !guard_i && pin_s && (low_cnt == SAT);

  a_r6_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    low_cnt <= SAT);
  a_r6_sat_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (low_cnt == SAT && !pin_s && !guard_i) |=> (low_cnt == SAT));
  a_r10_abort_evt_once: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt_o |=> !abort_evt_o);

endmodule

// File: rtl/dbgpin_ackctl.sv
module dbgpin_ackctl
  import dbgpin_abort_pkg::*;
#(
  parameter int ACK_LEN   = 16,
  parameter int GUARD_LEN = 3,
  localparam int AW = $clog2(ACK_LEN + 1),
  localparam int GW = $clog2(GUARD_LEN + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       abort_evt_i,
  input  logic       sync_evt_i,
  input  logic       cmd_pend_i,
  input  logic       cmd_done_i,
  input  logic       stop_i,
  input  logic [1:0] cmd_class_i,
  input  logic       acc_busy_i,
  output logic       pin_low_o,
  output logic       pin_high_o,
  output logic       abort_o,
  output logic       cancel_o,
  output logic       sync_req_o,
  output logic       guard_o
);

  ack_state_e    state_q;
  cmd_class_e    cls_q;
  logic [AW-1:0] ack_cnt;
  logic [GW-1:0] guard_cnt;
  logic          driving;
  logic          killable;

  assign driving  = (state_q == ST_ACKL) || (state_q == ST_SPDH);
  assign killable = (cls_q != CLS_RUN) && !acc_busy_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cls_q   <= CLS_OTHER;
      ack_cnt <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (cmd_pend_i) begin
          state_q <= ST_PEND;
          cls_q   <= cmd_class_e'(cmd_class_i);
        end
        ST_PEND: begin
          if (abort_evt_i || stop_i) begin
            state_q <= ST_IDLE;
          end else if (cmd_done_i) begin
            state_q <= ST_ACKL;
            ack_cnt <= AW'(ACK_LEN - 1);
          end
        end
        ST_ACKL: begin
          if (ack_cnt == '0) state_q <= ST_SPDH;
          else               ack_cnt <= ack_cnt - 1'b1;
        end
        ST_SPDH: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // settling window after own drive, covering synchronizer latency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               guard_cnt <= '0;
    else if (driving)         guard_cnt <= GW'(GUARD_LEN);
    else if (guard_cnt != '0) guard_cnt <= guard_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abort_o    <= 1'b0;
      cancel_o   <= 1'b0;
      sync_req_o <= 1'b0;
    end else begin
      abort_o    <= (state_q == ST_PEND) && abort_evt_i;
      cancel_o   <= (state_q == ST_PEND) && abort_evt_i && killable;
      sync_req_o <= sync_evt_i;
    end
  end

  assign pin_low_o  = (state_q == ST_ACKL);
  assign pin_high_o = (state_q == ST_SPDH);
  assign guard_o    = driving || (guard_cnt != '0);

  a_r2_drive_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(pin_low_o && pin_high_o));
  a_r2_speedup_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_high_o) |-> $past(pin_low_o));
  a_r2_speedup_one: assert property (@(posedge clk) disable iff (!rst_n)
    pin_high_o |=> !pin_high_o && !pin_low_o);
  a_r3_ack_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_low_o) |-> $past(cmd_done_i));
  a_r7_cancel_with_abort: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_o |-> abort_o);
  a_r10_abort_one: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> !abort_o);
  a_r10_sync_one: assert property (@(posedge clk) disable iff (!rst_n)
    sync_req_o |=> !sync_req_o);
  a_r9_no_abort_while_driving: assert property (@(posedge clk) disable iff (!rst_n)
    driving |=> !abort_o && !sync_req_o);

endmodule

// File: rtl/dbgpin_abort.sv
module dbgpin_abort #(
  parameter int SYNC_LEN  = 128,
  parameter int ABORT_MIN = 4,
  parameter int ACK_LEN   = 16,
  parameter int GUARD_LEN = 3,
  parameter int STAGES    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic       cmd_pend_i,
  input  logic       cmd_done_i,
  input  logic       stop_i,
  input  logic [1:0] cmd_class_i,
  input  logic       acc_busy_i,
  output logic       pin_low_o,
  output logic       pin_high_o,
  output logic       abort_o,
  output logic       cancel_o,
  output logic       sync_req_o
);

  logic abort_evt;
  logic sync_evt;
  logic guard;

  dbgpin_lowtimer #(
    .SYNC_LEN (SYNC_LEN),
    .ABORT_MIN(ABORT_MIN),
    .STAGES   (STAGES)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_i      (pin_i),
    .guard_i    (guard),
    .abort_evt_o(abort_evt),
    .sync_evt_o (sync_evt)
  );

  dbgpin_ackctl #(
    .ACK_LEN  (ACK_LEN),
    .GUARD_LEN(GUARD_LEN)
  ) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .abort_evt_i(abort_evt),
    .sync_evt_i (sync_evt),
    .cmd_pend_i (cmd_pend_i),
    .cmd_done_i (cmd_done_i),
    .stop_i     (stop_i),
    .cmd_class_i(cmd_class_i),
    .acc_busy_i (acc_busy_i),
    .pin_low_o  (pin_low_o),
    .pin_high_o (pin_high_o),
    .abort_o    (abort_o),
    .cancel_o   (cancel_o),
    .sync_req_o (sync_req_o),
    .guard_o    (guard)
  );

endmodule

// File: tb/dbgpin_abort_tb.sv
`timescale 1ns/1ps
module dbgpin_abort_tb;

  localparam int ACK_LEN = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_low = 1'b0;
  logic       pin_i;
  logic       cmd_pend = 1'b0;
  logic       cmd_done = 1'b0;
  logic       stop = 1'b0;
  logic [1:0] cls = 2'd0;
  logic       busy = 1'b0;
  logic       pin_low_o, pin_high_o, abort_o, cancel_o, sync_req_o;

  int checks = 0;
  int fails = 0;
  int n_abort = 0, n_cancel = 0, n_sync = 0, n_low = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  // open-drain pin: low if either side pulls it down
  assign pin_i = !(host_low || pin_low_o);

  dbgpin_abort u_dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
    .cmd_pend_i(cmd_pend), .cmd_done_i(cmd_done), .stop_i(stop),
    .cmd_class_i(cls), .acc_busy_i(busy),
    .pin_low_o(pin_low_o), .pin_high_o(pin_high_o),
    .abort_o(abort_o), .cancel_o(cancel_o), .sync_req_o(sync_req_o)
  );

  always @(negedge clk) begin
    if (abort_o)    n_abort++;
    if (cancel_o)   n_cancel++;
    if (sync_req_o) n_sync++;
    if (pin_low_o)  n_low++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue_cmd(input logic [1:0] c);
    @(negedge clk); cmd_pend = 1'b1; cls = c;
    @(negedge clk); cmd_pend = 1'b0;
  endtask

  task automatic host_pulse(input int len);
    @(negedge clk); host_low = 1'b1;
    repeat (len) @(negedge clk);
    host_low = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic strobe_done();
    @(negedge clk); cmd_done = 1'b1;
    @(negedge clk); cmd_done = 1'b0;
  endtask

  // full acknowledge check, R2 timing and R9 self-insensitivity
  task automatic ack_expected(input string req);
    int lows = 0;
    int a0 = n_abort;
    int s0 = n_sync;
    int hi = 0;
    strobe_done();
    while (pin_low_o && !pin_high_o && lows < 200) begin
      lows++;
      @(negedge clk);
    end
    hi = pin_high_o;
    check({req, " ack low length"}, lows, ACK_LEN);
    check({req, " speedup high"}, hi, 1);
    @(negedge clk);
    check({req, " released after speedup"}, int'(pin_low_o) + int'(pin_high_o), 0);
    repeat (8) @(negedge clk);
    check("R9 own ack no abort", n_abort - a0, 0);
    check("R9 own ack no sync", n_sync - s0, 0);
  endtask

  task automatic no_ack_expected(input string req);
    int l0 = n_low;
    strobe_done();
    repeat (ACK_LEN + 4) @(negedge clk);
    check({req, " no ack driven"}, n_low - l0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pin_low", pin_low_o, 0);
    check("R1 pin_high", pin_high_o, 0);
    check("R1 strobes", int'(abort_o) + int'(cancel_o) + int'(sync_req_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 normal acknowledge
    issue_cmd(2'd1);
    ack_expected("R2");

    // R3 nested command ignored, unmatched done ignored
    issue_cmd(2'd0);
    issue_cmd(2'd3);
    ack_expected("R3 nested");
    no_ack_expected("R3 unmatched");

    // R5/R6/R7 sweep of pulse lengths, pending and idle
    for (int pend = 0; pend < 2; pend++) begin
      for (int len = 1; len <= 135; len++) begin
        int a0, c0, s0;
        logic [1:0] c;
        logic b;
        c = 2'(len % 4);
        b = (len / 4) % 2 == 1;
        if (pend == 1) issue_cmd(c);
        busy = b;
        a0 = n_abort; c0 = n_cancel; s0 = n_sync;
        host_pulse(len);
        busy = 1'b0;
        check($sformatf("R5 abort len=%0d pend=%0d", len, pend),
              n_abort - a0, (pend == 1 && len >= 4) ? 1 : 0);
        check($sformatf("R7 cancel len=%0d cls=%0d busy=%0d", len, c, b),
              n_cancel - c0,
              (pend == 1 && len >= 4 && c != 2'd3 && !b) ? 1 : 0);
        check($sformatf("R6 sync len=%0d pend=%0d", len, pend),
              n_sync - s0, (len >= 128) ? 1 : 0);
        if (pend == 1 && len < 4) begin
          // R4: stop drops the surviving command
          int a1 = n_abort;
          @(negedge clk); stop = 1'b1;
          @(negedge clk); stop = 1'b0;
          no_ack_expected("R4 stop");
          check("R4 stop no abort", n_abort - a1, 0);
        end else if (pend == 1) begin
          no_ack_expected("R5 aborted");
        end
        if (pend == 1 && (len == 4 || len == 130)) begin
          issue_cmd(2'd2);
          ack_expected($sformatf("R8 rearm len=%0d", len));
        end
      end
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule